// File: doc/BRIEF.md
# Receive Path Parity Monitor and Return Status Byte Builder

This block sits on the receive side of a cell-framing link. It recomputes an eight-bit bit-interleaved even parity over every byte of each received frame. It then checks that parity against the parity byte carried in the following frame and counts how many of the eight bit positions disagree. From that count and a time-qualified remote alarm it builds a one-byte status word. The local transmitter puts that word into its next outbound frame, so the far end learns how well its frames arrive.

Received bytes enter on a valid/ready stream, with sideband flags marking the first byte of a frame and the byte that carries the parity. The block never applies back-pressure: `rx_ready` is low only while reset is held, and it is high from the first clock after reset. A byte is taken in every cycle where `rx_valid` and `rx_ready` are both high. The status word leaves on a valid/ready stream. A word stays valid and unchanged until `g1_ready` is seen high. If a newer word is built before that, the newer word replaces the waiting one, because only the most recent status matters to the far end. The framed indication, the one-second tick and the alarm threshold are plain level inputs.

Top module: `bip_g1_gen`

## Requirements
- R1: The parity of a frame is the bitwise XOR (per-bit even parity) of every byte accepted from the byte flagged `rx_sof` up to, but not including, the next byte flagged `rx_sof`. The parity byte itself is part of the frame it sits in.
- R2: When the parity-position byte (`rx_b1`) of a frame is accepted, it is compared with the parity of the previous frame. The error count is the population count of their XOR: 0 when they are equal, and never more than 8.
- R3: Status word layout: bits 7:4 hold the error count, bit 3 holds the remote alarm, and bits 2:0 are always 000.
- R4: Accepting a byte with `rx_b1` high builds exactly one status word. `g1_valid` is high in the cycle after that byte is accepted.
- R5: A valid status word holds its value while `g1_ready` is low, and it drops after a cycle with `g1_ready` high. A newer word overwrites a word that is still waiting.
- R6: While `framed` is low, no comparison is made and the error count is 0.
- R7: After reset, or after `framed` returns, the first frame that starts while framed produces no comparison (count 0). The frame after it is compared.
- R8: Each `sec_tick` seen while `framed` is low advances a seconds counter. The remote alarm is set when the counter reaches the threshold `cfg_rai_secs`, clamped to the range 2 to 10 (0 and 1 act as 2, and 11 to 15 act as 10).
- R9: A cycle with `framed` high clears the alarm and the seconds counter.
- R10: `rx_ready` is low in reset and high afterwards. Cycles with `rx_valid` low change nothing, whatever the data and flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_b1 | input | 1 | Byte is the parity-carrying byte |
| framed | input | 1 | Receive framer is in frame |
| sec_tick | input | 1 | One-cycle pulse each second |
| cfg_rai_secs | input | 4 | Unframed seconds before the alarm |
| g1_data | output | 8 | Status word |
| g1_valid | output | 1 | Status word present |
| g1_ready | input | 1 | Status word taken |

## Verification
Several corner cases are driven. The parity byte is XOR-masked with patterns of zero to eight flipped bits; a wrong population count or a missing self-inclusion of the parity byte shows up as a wrong error count. The first frame after reset and after reframing must report 0; a design that compares against stale parity reports garbage there. The alarm is checked one tick before and at the threshold, including both clamp ends, and again after reframing. A counter that is not cleared sets the alarm too early. Finally, the status word is held under back-pressure and then overwritten; a design that drops or freezes it fails there.

// File: rtl/bipg1_pkg.sv
package bipg1_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int XBITS  = 3;

  typedef struct packed {
    logic [CNT_W-1:0] febe;
    logic             rai;
    logic [XBITS-1:0] xbits;
  } status_t;
endpackage

// File: rtl/bip_accum.sv
module bip_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         sof,
  input  logic         framed,
  input  logic [W-1:0] data,
  output logic [W-1:0] ref_bip,
  output logic         ref_ok
);
  logic [W-1:0] acc_q, prev_q;
  logic         have_q, prev_ok_q;

  // a start byte closes the running frame in the same cycle
  always_comb begin
    ref_bip = sof ? acc_q  : prev_q;
    ref_ok  = sof ? have_q : prev_ok_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      prev_q    <= '0;
      have_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (!framed) begin
      have_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (take) begin
      if (sof) begin
        prev_q    <= acc_q;
        prev_ok_q <= have_q;
        acc_q     <= data;
        have_q    <= 1'b1;
      end else begin
        acc_q <= acc_q ^ data;
      end
    end
  end
endmodule

// File: rtl/bit_diff_count.sv
module bit_diff_count #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [CW-1:0] count
);
  logic [W-1:0]  diff;
  logic [CW-1:0] part [W+1];

  assign diff    = a ^ b;
  assign part[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign part[i+1] = part[i] + CW'(diff[i]);
  end

  assign count = part[W];
endmodule

// File: rtl/rai_timer.sv
module rai_timer #(
  parameter int CFG_W    = 4,
  parameter int MIN_SECS = 2,
  parameter int MAX_SECS = 10,
  localparam int SW = $clog2(MAX_SECS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             framed,
  input  logic             tick,
  input  logic [CFG_W-1:0] cfg_secs,
  output logic             rai
);
  logic [SW-1:0] secs_q, limit;

  always_comb begin
    if (int'(cfg_secs) < MIN_SECS)      limit = SW'(MIN_SECS);
    else if (int'(cfg_secs) > MAX_SECS) limit = SW'(MAX_SECS);
    else                                limit = SW'(cfg_secs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || framed) begin
      secs_q <= '0;
      rai    <= 1'b0;
    end else if (tick && !rai) begin
      secs_q <= secs_q + 1'b1;
      if (secs_q + 1'b1 >= limit) rai <= 1'b1;
    end
  end
endmodule

// File: rtl/status_out.sv
module status_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid,
  input  logic         ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      dout  <= din;
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bip_g1_gen.sv
module bip_g1_gen
  import bipg1_pkg::*;
#(
  parameter int CFG_W    = 4,
  parameter int MIN_SECS = 2,
  parameter int MAX_SECS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_sof,
  input  logic             rx_b1,
  input  logic             framed,
  input  logic             sec_tick,
  input  logic [CFG_W-1:0] cfg_rai_secs,
  output logic [7:0]       g1_data,
  output logic             g1_valid,
  input  logic             g1_ready
);
  localparam int DCW = $clog2(BYTE_W + 1);

  logic              take, build, rai;
  logic [BYTE_W-1:0] ref_bip;
  logic              ref_ok;
  logic [DCW-1:0]    diff_cnt;
  status_t           word;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_ready <= 1'b0;
    else        rx_ready <= 1'b1;
  end

  assign take  = rx_valid && rx_ready;
  assign build = take && rx_b1;

  bip_accum #(.W(BYTE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(rx_sof), .framed(framed),
    .data(rx_data), .ref_bip(ref_bip), .ref_ok(ref_ok)
  );

  bit_diff_count #(.W(BYTE_W)) u_cnt (
    .a(ref_bip), .b(rx_data), .count(diff_cnt)
  );

  rai_timer #(.CFG_W(CFG_W), .MIN_SECS(MIN_SECS), .MAX_SECS(MAX_SECS)) u_rai (
    .clk(clk), .rst_n(rst_n), .framed(framed), .tick(sec_tick),
    .cfg_secs(cfg_rai_secs), .rai(rai)
  );

  always_comb begin
    word.febe  = (framed && ref_ok) ? CNT_W'(diff_cnt) : '0;
    word.rai   = rai;
    word.xbits = '0;
  end

  status_out #(.W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(build), .din(word),
    .dout(g1_data), .valid(g1_valid), .ready(g1_ready)
  );
endmodule

// File: rtl/bip_g1_chk.sv
module bip_g1_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_b1,
  input logic       framed,
  input logic       rai,
  input logic [7:0] g1_data,
  input logic       g1_valid,
  input logic       g1_ready
);
  // R2
  febe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g1_valid |-> g1_data[7:4] <= 4'd8);
  // R3
  xbits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g1_valid |-> g1_data[2:0] == 3'b000);
  // R4
  build_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_b1) |=> g1_valid);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_valid && !g1_ready && !(rx_valid && rx_ready && rx_b1)) |=> (g1_valid && $stable(g1_data)));
  // R6
  unframed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_b1 && !framed) |=> g1_data[7:4] == 4'd0);
  // R9
  rai_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    framed |=> !rai);
  // R10
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> rx_ready);
endmodule

bind bip_g1_gen bip_g1_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_b1(rx_b1), .framed(framed), .rai(rai), .g1_data(g1_data),
  .g1_valid(g1_valid), .g1_ready(g1_ready)
);

// File: tb/test_bip_g1_gen.sv
module test_bip_g1_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_b1 = 1'b0;
  logic       framed = 1'b0, sec_tick = 1'b0, g1_ready = 1'b1;
  logic [3:0] cfg_rai_secs = 4'd3;
  logic       rx_ready, g1_valid;
  logic [7:0] g1_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_prev = '0;
  logic       m_prev_ok = 1'b0, m_have = 1'b0;

  // seed in the high byte, parity mask in the low byte
  localparam logic [15:0] VEC [8] = '{
    16'h1100, 16'h2201, 16'h3380, 16'h4403,
    16'h55F0, 16'h66FF, 16'h7755, 16'h8800
  };

  bip_g1_gen i_bip_g1_gen (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_b1(rx_b1), .framed(framed),
    .sec_tick(sec_tick), .cfg_rai_secs(cfg_rai_secs), .g1_data(g1_data),
    .g1_valid(g1_valid), .g1_ready(g1_ready)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic int popc(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic b);
    rx_data = d; rx_sof = s; rx_b1 = b; rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_b1 = 1'b0; rx_data = 8'hA5;
  endtask

  task automatic tick();
    sec_tick = 1'b1; @(posedge clk); @(negedge clk); sec_tick = 1'b0;
  endtask

  // six-byte frame: start byte, parity byte, four payload bytes
  task automatic frame(input logic [7:0] seed, input logic [7:0] mask,
                       input logic exp_rai, input string req);
    logic [7:0] acc, b1v, d;
    int exp_cnt;
    if (framed) begin
      m_prev_ok = m_have;
      m_have = 1'b1;
    end
    b1v = m_prev ^ mask;
    exp_cnt = (framed && m_prev_ok) ? popc(mask) : 0;
    put(seed, 1'b1, 1'b0);
    acc = seed;
    put(b1v, 1'b0, 1'b1);
    acc ^= b1v;
    check({req, " valid"}, 32'(g1_valid), 32'd1);
    check({req, " word"}, 32'(g1_data), 32'({4'(exp_cnt), exp_rai, 3'b000}));
    for (int i = 0; i < 4; i++) begin
      d = seed + 8'(i * 37 + 5);
      // an idle cycle with noisy data and flags must be ignored (R10)
      rx_data = 8'hFF; rx_sof = 1'b1; rx_b1 = 1'b1;
      @(posedge clk); @(negedge clk);
      rx_sof = 1'b0; rx_b1 = 1'b0;
      put(d, 1'b0, 1'b0);
      acc ^= d;
    end
    m_prev = acc;
  endtask

  task automatic unframe();
    framed = 1'b0; m_have = 1'b0; m_prev_ok = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready in reset", 32'(rx_ready), 32'd0);
    check("R4 no word in reset", 32'(g1_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", 32'(rx_ready), 32'd1);
    framed = 1'b1;
    @(negedge clk);

    // R7 first frame after reset not compared, R1/R2/R3 table walk
    frame(8'h3C, 8'hFF, 1'b0, "R7 first frame");
    for (int k = 0; k < 8; k++)
      frame(VEC[k][15:8], VEC[k][7:0], 1'b0, "R2 vector");

    // R5 hold under back-pressure, then overwrite
    g1_ready = 1'b0;
    frame(8'h91, 8'h07, 1'b0, "R5 first");
    repeat (3) @(negedge clk);
    check("R5 held valid", 32'(g1_valid), 32'd1);
    check("R5 held data", 32'(g1_data), 32'h30);
    frame(8'h92, 8'h01, 1'b0, "R5 overwrite");
    g1_ready = 1'b1;
    @(negedge clk);
    check("R5 drop after ready", 32'(g1_valid), 32'd0);

    // R6 and R8 threshold 3
    cfg_rai_secs = 4'd3;
    unframe();
    tick(); tick();
    frame(8'h10, 8'hFF, 1'b0, "R6 R8 below threshold");
    tick();
    frame(8'h20, 8'h0F, 1'b1, "R8 at threshold");

    // R9 reframing clears alarm; R7 first frame after reframe
    framed = 1'b1;
    @(negedge clk);
    frame(8'h30, 8'hF0, 1'b0, "R9 R7 reframe");
    frame(8'h40, 8'h03, 1'b0, "R7 second frame compared");

    // R9 counter reset: clamp low, threshold 0 behaves as 2
    cfg_rai_secs = 4'd0;
    unframe();
    tick();
    frame(8'h50, 8'h00, 1'b0, "R9 R8 clamp low one tick");
    tick();
    frame(8'h51, 8'h00, 1'b1, "R8 clamp low two ticks");

    // R8 clamp high: 15 behaves as 10
    framed = 1'b1; @(negedge clk);
    cfg_rai_secs = 4'd15;
    unframe();
    for (int t = 0; t < 9; t++) tick();
    frame(8'h60, 8'h00, 1'b0, "R8 clamp high nine ticks");
    tick();
    frame(8'h61, 8'h00, 1'b1, "R8 clamp high ten ticks");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule